// File: doc/BRIEF.md
# 64-bit PCI initiator write sequencer

This block is the bus-master engine for burst memory writes onto a 64-bit PCI bus. A local master asks for a transfer. It gives the target address, the number of QWORD data phases and whether a 64-bit transfer is wanted. The sequencer then requests the bus, waits for grant and runs one address phase. It waits for the target's device select and pauses a fixed width-decision window. It then streams the data phases, ends framing on the last phase and hands the bus back in two release steps.

The local side uses a pipelined handshake. The master keeps a QWORD and its byte enables on its data inputs. A transfer strobe tells it that the word is captured at the next clock edge. Until it sees the strobe, the master holds the same word. The low-half strobe marks every captured word. The high-half strobe is also raised when the transfer is 64 bits wide. The PCI control lines are active-low. Each driven group has its own output enable, so the pad logic can release that group to high impedance.

Top module: `pci64w_wr_init`

## Requirements
- R1: After reset every output enable is low, `pci_req_n` is high, both strobes are low, `loc_is64` is 0, `loc_burst_cnt` is 0, and `loc_status`/`loc_term` read 0 (idle / none).
- R2: `loc_gnt_n` always equals `pci_gnt_n` in the same cycle.
- R3: Bus request and grant.
  - `loc_req` high in an idle cycle drives `pci_req_n` low in the next cycle.
  - No address phase happens while `pci_gnt_n` is high. The address phase is the cycle after the first request cycle in which grant is low.
  - `pci_req_n` goes high one cycle after a cycle in which frame is driven low, provided `loc_req` was low in the cycle before that one.
- R4: The address phase lasts one cycle.
  - `frame_oe`=1 and `frame_n_o`=0.
  - `ad_o[31:0]` equals the `loc_data` present in the cycle grant was accepted.
  - `cbe_o[3:0]`=4'b0111 (memory write).
  - `req64_n_o` is low if and only if `loc_want64` was high at the request.
- R5: Width-decision window.
  - Once `pci_devsel_n` has been sampled low, `irdy_n_o` stays high and both strobes stay low for exactly 2 cycles (WIDTH_WAIT).
  - In the cycle after the window, `loc_status` reads 4'h4 (data).
  - In that same cycle `loc_is64` is 1 if and only if a 64-bit transfer was requested and `pci_ack64_n` was low in the last window cycle.
  - In that same cycle a strobe is raised if `loc_rdy` is high.
- R6: Local strobes.
  - A strobe is high only while `loc_status` is data, and it means `loc_data`/`loc_be` are captured at the next edge.
  - Exactly `loc_len` strobes occur per transfer.
  - The words appear on the bus in order, with no word lost or repeated, each with its byte enables.
- R7: `irdy_n_o` falls only in a cycle that directly follows a cycle with `loc_xfer_lo` high.
- R8: A data phase completes in any cycle with `irdy_n_o` and `pci_trdy_n` both low. Each completion lowers `loc_burst_cnt` by one.
- R9: During the final data phase, `frame_n_o` and `req64_n_o` are high while `irdy_n_o` is low, and both strobes are low. During every earlier phase, `frame_n_o` is low.
- R10: In the cycle after the last phase completes, all of the following hold.
  - `frame_oe`, `req64_oe`, `ad_lo_oe`, `ad_hi_oe`, `cbe_lo_oe` and `cbe_hi_oe` are low.
  - `irdy_oe`=1 and `irdy_n_o`=1.
  - `loc_burst_cnt`=0.
  - `loc_status`=4'h8 (bus termination) and `loc_term`=2'b01 (normal).
- R11: One cycle after the R10 cycle, `irdy_oe` and `par_oe` are low.
- R12: When `loc_rdy` is low as a word slot frees, `irdy_n_o` goes high, frame stays low and `ad_o` keeps its value until a new word is captured.
- R13: When the transfer is resolved as 32-bit, `loc_xfer_hi` never rises, and `ad_hi_oe`/`cbe_hi_oe` stay low throughout the data phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_req | input | 1 | Local master asks for a write transfer |
| loc_want64 | input | 1 | Local master asks for 64-bit width |
| loc_len | input | CNT_W | Number of QWORD data phases (0 treated as 1) |
| loc_rdy | input | 1 | Local word on loc_data is valid |
| loc_data | input | DW | Address before the address phase, then data words |
| loc_be | input | DW/8 | Active-low byte enables of the local word |
| loc_xfer_lo | output | 1 | Low half of the local word is captured at next edge |
| loc_xfer_hi | output | 1 | High half of the local word is captured at next edge |
| loc_is64 | output | 1 | Transfer resolved as 64-bit |
| loc_gnt_n | output | 1 | Copy of the PCI grant |
| loc_status | output | 4 | Sequencer phase code |
| loc_term | output | 2 | Termination code |
| loc_burst_cnt | output | CNT_W | Data phases still to complete |
| pci_req_n | output | 1 | Bus request |
| pci_gnt_n | input | 1 | Bus grant |
| frame_n_o | output | 1 | Frame value |
| frame_oe | output | 1 | Frame drive enable |
| req64_n_o | output | 1 | 64-bit request value |
| req64_oe | output | 1 | 64-bit request drive enable |
| irdy_n_o | output | 1 | Initiator-ready value |
| irdy_oe | output | 1 | Initiator-ready drive enable |
| ad_o | output | DW | Address/data value |
| ad_lo_oe | output | 1 | Drive enable, address/data low half |
| ad_hi_oe | output | 1 | Drive enable, address/data high half |
| cbe_o | output | DW/8 | Command/byte-enable value |
| cbe_lo_oe | output | 1 | Drive enable, command/byte-enable low half |
| cbe_hi_oe | output | 1 | Drive enable, command/byte-enable high half |
| par_oe | output | 1 | Drive enable for both parity lines |
| pci_devsel_n | input | 1 | Target device select |
| pci_ack64_n | input | 1 | Target accepts 64-bit width |
| pci_trdy_n | input | 1 | Target ready |

## Verification
The main burst is run with several target behaviours.
- A target that accepts 64-bit width, one that answers a 64-bit request with 32-bit width, and a plain 32-bit request. These tell the width decision and the high-half gating apart.
- A single-phase burst, where frame must rise on the very first data phase.
- Local ready patterns with gaps, which exercise initiator wait states and data holding.
- Target-ready patterns with gaps, which stretch phases without any new word being taken.
- Mixed patterns of both kinds.
- Different device-select delays and a withheld grant, which show that the width window counts from device select and that no address phase starts before grant.

// File: rtl/pci64w_pkg.sv
// Shared types and codes of the 64-bit PCI initiator write sequencer.
package pci64w_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_REQ, ST_ADDR, ST_DEVW, ST_DATA, ST_TURN, ST_REL
    } wr_state_t;

    localparam logic [3:0] STAT_IDLE    = 4'h0;
    localparam logic [3:0] STAT_REQ     = 4'h1;
    localparam logic [3:0] STAT_ADDR    = 4'h2;
    localparam logic [3:0] STAT_DATA    = 4'h4;
    localparam logic [3:0] STAT_BUSTERM = 4'h8;

    localparam logic [1:0] TERM_NONE   = 2'b00;
    localparam logic [1:0] TERM_NORMAL = 2'b01;

    localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;
endpackage

// File: rtl/pci64w_ctrl.sv
// Sequencer control: request, address phase, width window, data phases,
// last-phase framing and release. Assumes a single-word bus slot: a new
// word is captured only when the slot is empty or its phase completes.
module pci64w_ctrl
    import pci64w_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int WIDTH_WAIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_req,
    input  logic             loc_want64,
    input  logic [CNT_W-1:0] loc_len,
    input  logic             loc_rdy,
    input  logic             gnt_n,
    input  logic             devsel_n,
    input  logic             ack64_n,
    input  logic             trdy_n,
    output wr_state_t        state,
    output logic             addr_take,
    output logic             data_take,
    output logic             is64,
    output logic             req_act,
    output logic             frame_act,
    output logic             req64_act,
    output logic             irdy_act,
    output logic [CNT_W-1:0] burst_cnt,
    output logic [3:0]       status,
    output logic [1:0]       term
);
    localparam int WW_W = $clog2(WIDTH_WAIT + 1);
    localparam logic [WW_W-1:0] WW_LAST = WW_W'(WIDTH_WAIT - 1);

    logic             want64_q;
    logic             dsel_seen;
    logic [WW_W-1:0]  wcnt;
    logic [CNT_W-1:0] fetch_left;
    logic             req_prev;
    logic             complete;
    logic             slot_free;

    // Phase completion, slot availability and word capture decisions.
    always_comb begin
        complete  = (state == ST_DATA) && irdy_act && !trdy_n;
        slot_free = !irdy_act || complete;
        data_take = (state == ST_DATA) && slot_free && loc_rdy && (fetch_left != '0);
        addr_take = (state == ST_REQ) && !gnt_n;
    end

    // Main sequencing register block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            want64_q   <= 1'b0;
            dsel_seen  <= 1'b0;
            wcnt       <= '0;
            fetch_left <= '0;
            burst_cnt  <= '0;
            is64       <= 1'b0;
            req_act    <= 1'b0;
            frame_act  <= 1'b0;
            req64_act  <= 1'b0;
            irdy_act   <= 1'b0;
            status     <= STAT_IDLE;
            term       <= TERM_NONE;
            req_prev   <= 1'b0;
        end else begin
            req_prev <= loc_req;
            case (state)
                ST_IDLE: begin
                    if (loc_req) begin
                        state      <= ST_REQ;
                        req_act    <= 1'b1;
                        want64_q   <= loc_want64;
                        fetch_left <= (loc_len == '0) ? CNT_W'(1) : loc_len;
                        burst_cnt  <= (loc_len == '0) ? CNT_W'(1) : loc_len;
                        is64       <= 1'b0;
                        status     <= STAT_REQ;
                        term       <= TERM_NONE;
                    end
                end
                ST_REQ: begin
                    if (addr_take) begin
                        state     <= ST_ADDR;
                        frame_act <= 1'b1;
                        req64_act <= want64_q;
                        status    <= STAT_ADDR;
                    end
                end
                ST_ADDR: begin
                    state     <= ST_DEVW;
                    dsel_seen <= 1'b0;
                    wcnt      <= '0;
                end
                ST_DEVW: begin
                    if (!dsel_seen) begin
                        if (!devsel_n) begin
                            dsel_seen <= 1'b1;
                            wcnt      <= '0;
                        end
                    end else if (wcnt == WW_LAST) begin
                        state  <= ST_DATA;
                        is64   <= want64_q && !ack64_n;
                        status <= STAT_DATA;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (data_take) begin
                        irdy_act   <= 1'b1;
                        fetch_left <= fetch_left - 1'b1;
                        if (fetch_left == CNT_W'(1)) begin
                            frame_act <= 1'b0;
                            req64_act <= 1'b0;
                        end
                    end else if (complete) begin
                        irdy_act <= 1'b0;
                    end
                    if (complete) begin
                        burst_cnt <= burst_cnt - 1'b1;
                        if (burst_cnt == CNT_W'(1)) begin
                            state    <= ST_TURN;
                            irdy_act <= 1'b0;
                            status   <= STAT_BUSTERM;
                            term     <= TERM_NORMAL;
                        end
                    end
                end
                ST_TURN: state <= ST_REL;
                default: state <= ST_IDLE;
            endcase
            if (req_act && frame_act && !req_prev) begin
                req_act <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pci64w_dpath.sv
// Bus word register: captures the address with the memory-write command
// at grant, then each local word with its byte enables on a data capture.
// Holds its value otherwise, which keeps the bus stable in wait states.
module pci64w_dpath
    import pci64w_pkg::*;
#(
    parameter int DW   = 64,
    parameter int BE_W = DW / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_take,
    input  logic            data_take,
    input  logic [DW-1:0]   din,
    input  logic [BE_W-1:0] be_in,
    output logic [DW-1:0]   ad_q,
    output logic [BE_W-1:0] cbe_q
);
    // Load address or data word into the bus register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_q  <= '0;
            cbe_q <= '0;
        end else if (addr_take) begin
            ad_q  <= din;
            cbe_q <= {{(BE_W-4){1'b0}}, CMD_MEM_WRITE};
        end else if (data_take) begin
            ad_q  <= din;
            cbe_q <= be_in;
        end
    end
endmodule

// File: rtl/pci64w_oe.sv
// Output-enable decode per signal group from the sequencer state.
// The high halves are driven only in data phases of a 64-bit transfer.
module pci64w_oe
    import pci64w_pkg::*;
(
    input  wr_state_t state,
    input  logic      is64,
    output logic      frame_oe,
    output logic      req64_oe,
    output logic      lo_oe,
    output logic      hi_oe,
    output logic      irdy_oe,
    output logic      par_oe
);
    // Group enables follow the ownership window of each signal.
    always_comb begin
        frame_oe = (state == ST_ADDR) || (state == ST_DEVW) || (state == ST_DATA);
        req64_oe = frame_oe;
        lo_oe    = frame_oe;
        hi_oe    = (state == ST_DATA) && is64;
        irdy_oe  = (state == ST_DEVW) || (state == ST_DATA) || (state == ST_TURN);
        par_oe   = irdy_oe;
    end
endmodule

// File: rtl/pci64w_wr_init.sv
// Top of the 64-bit PCI initiator write sequencer. Connects the control
// engine, the bus word register and the output-enable decode. PCI control
// values are active-low; each group has a separate drive enable.
module pci64w_wr_init
    import pci64w_pkg::*;
#(
    parameter int DW         = 64,
    parameter int CNT_W      = 8,
    parameter int WIDTH_WAIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_req,
    input  logic             loc_want64,
    input  logic [CNT_W-1:0] loc_len,
    input  logic             loc_rdy,
    input  logic [DW-1:0]    loc_data,
    input  logic [DW/8-1:0]  loc_be,
    output logic             loc_xfer_lo,
    output logic             loc_xfer_hi,
    output logic             loc_is64,
    output logic             loc_gnt_n,
    output logic [3:0]       loc_status,
    output logic [1:0]       loc_term,
    output logic [CNT_W-1:0] loc_burst_cnt,
    output logic             pci_req_n,
    input  logic             pci_gnt_n,
    output logic             frame_n_o,
    output logic             frame_oe,
    output logic             req64_n_o,
    output logic             req64_oe,
    output logic             irdy_n_o,
    output logic             irdy_oe,
    output logic [DW-1:0]    ad_o,
    output logic             ad_lo_oe,
    output logic             ad_hi_oe,
    output logic [DW/8-1:0]  cbe_o,
    output logic             cbe_lo_oe,
    output logic             cbe_hi_oe,
    output logic             par_oe,
    input  logic             pci_devsel_n,
    input  logic             pci_ack64_n,
    input  logic             pci_trdy_n
);
    localparam int BE_W = DW / 8;

    wr_state_t st;
    logic addr_take, data_take, is64;
    logic req_act, frame_act, req64_act, irdy_act;
    logic lo_oe, hi_oe;

    pci64w_ctrl #(.CNT_W(CNT_W), .WIDTH_WAIT(WIDTH_WAIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .loc_req(loc_req), .loc_want64(loc_want64),
        .loc_len(loc_len), .loc_rdy(loc_rdy), .gnt_n(pci_gnt_n),
        .devsel_n(pci_devsel_n), .ack64_n(pci_ack64_n), .trdy_n(pci_trdy_n),
        .state(st), .addr_take(addr_take), .data_take(data_take), .is64(is64),
        .req_act(req_act), .frame_act(frame_act), .req64_act(req64_act),
        .irdy_act(irdy_act), .burst_cnt(loc_burst_cnt), .status(loc_status),
        .term(loc_term)
    );

    pci64w_dpath #(.DW(DW), .BE_W(BE_W)) u_dpath (
        .clk(clk), .rst_n(rst_n), .addr_take(addr_take), .data_take(data_take),
        .din(loc_data), .be_in(loc_be), .ad_q(ad_o), .cbe_q(cbe_o)
    );

    pci64w_oe u_oe (
        .state(st), .is64(is64), .frame_oe(frame_oe), .req64_oe(req64_oe),
        .lo_oe(lo_oe), .hi_oe(hi_oe), .irdy_oe(irdy_oe), .par_oe(par_oe)
    );

    // Port-level mapping of active-high internal flags to bus polarity.
    always_comb begin
        loc_xfer_lo = data_take;
        loc_xfer_hi = data_take && is64;
        loc_is64    = is64;
        loc_gnt_n   = pci_gnt_n;
        pci_req_n   = !req_act;
        frame_n_o   = !frame_act;
        req64_n_o   = !req64_act;
        irdy_n_o    = !irdy_act;
        ad_lo_oe    = lo_oe;
        cbe_lo_oe   = lo_oe;
        ad_hi_oe    = hi_oe;
        cbe_hi_oe   = hi_oe;
    end
endmodule

// File: rtl/pci64w_chk.sv
// Protocol checker for the write sequencer, attached by bind.
module pci64w_chk
    import pci64w_pkg::*;
#(
    parameter int DW    = 64,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             loc_xfer_lo,
    input logic             loc_xfer_hi,
    input logic             loc_is64,
    input logic [3:0]       loc_status,
    input logic [1:0]       loc_term,
    input logic [CNT_W-1:0] loc_burst_cnt,
    input logic             frame_n_o,
    input logic             frame_oe,
    input logic             req64_n_o,
    input logic             irdy_n_o,
    input logic             irdy_oe,
    input logic [DW-1:0]    ad_o,
    input logic             ad_lo_oe,
    input logic             ad_hi_oe,
    input logic             par_oe,
    input logic             pci_trdy_n
);
    AST_STROBE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        loc_xfer_lo |-> (loc_status == STAT_DATA)); // R6
    AST_IRDY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy_oe && $fell(irdy_n_o)) |-> $past(loc_xfer_lo)); // R7
    AST_PHASE_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy_oe && !irdy_n_o && !pci_trdy_n) |=> (loc_burst_cnt == CNT_W'($past(loc_burst_cnt) - 1'b1))); // R8
    AST_LAST_PHASE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_oe && frame_n_o && irdy_oe && !irdy_n_o) |-> (!loc_xfer_lo && req64_n_o)); // R9
    AST_TURN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_oe) |-> (irdy_oe && irdy_n_o && loc_burst_cnt == '0
                             && loc_status == STAT_BUSTERM && loc_term == TERM_NORMAL)); // R10
    AST_IRDY_PAR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irdy_oe) |-> (!par_oe && !frame_oe)); // R11
    AST_WAIT_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy_oe && irdy_n_o && $past(irdy_n_o) && ad_lo_oe && $past(ad_lo_oe) && !$past(loc_xfer_lo))
        |-> $stable(ad_o)); // R12
    AST_HI_STROBE_64: assert property (@(posedge clk) disable iff (!rst_n)
        loc_xfer_hi |-> (loc_xfer_lo && loc_is64)); // R13
    AST_HI_DRIVE_64: assert property (@(posedge clk) disable iff (!rst_n)
        ad_hi_oe |-> loc_is64); // R13
endmodule

bind pci64w_wr_init pci64w_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .loc_xfer_lo(loc_xfer_lo), .loc_xfer_hi(loc_xfer_hi),
    .loc_is64(loc_is64), .loc_status(loc_status), .loc_term(loc_term),
    .loc_burst_cnt(loc_burst_cnt), .frame_n_o(frame_n_o), .frame_oe(frame_oe),
    .req64_n_o(req64_n_o), .irdy_n_o(irdy_n_o), .irdy_oe(irdy_oe), .ad_o(ad_o),
    .ad_lo_oe(ad_lo_oe), .ad_hi_oe(ad_hi_oe), .par_oe(par_oe), .pci_trdy_n(pci_trdy_n)
);

// File: tb/sim_pci64w_wr_init.sv
module sim_pci64w_wr_init;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loc_req = 1'b0, loc_want64 = 1'b0, loc_rdy = 1'b0;
    logic [7:0] loc_len = '0;
    logic [63:0] loc_data = '0;
    logic [7:0] loc_be = '0;
    logic loc_xfer_lo, loc_xfer_hi, loc_is64, loc_gnt_n;
    logic [3:0] loc_status;
    logic [1:0] loc_term;
    logic [7:0] loc_burst_cnt;
    logic pci_req_n, pci_gnt_n = 1'b1;
    logic frame_n_o, frame_oe, req64_n_o, req64_oe, irdy_n_o, irdy_oe;
    logic [63:0] ad_o;
    logic ad_lo_oe, ad_hi_oe, cbe_lo_oe, cbe_hi_oe, par_oe;
    logic [7:0] cbe_o;
    logic pci_devsel_n = 1'b1, pci_ack64_n = 1'b1, pci_trdy_n = 1'b1;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    pci64w_wr_init u0 (.*);

    // {gnt_delay[4], len[4], want64, ack64, devsel_dly[2], rdy_pat[8], trdy_pat[8]}
    localparam logic [27:0] VEC [8] = '{
        {4'd0, 4'd3, 1'b1, 1'b1, 2'd0, 8'hFF, 8'hFF},
        {4'd0, 4'd4, 1'b1, 1'b0, 2'd1, 8'hFF, 8'hFF},
        {4'd0, 4'd5, 1'b0, 1'b0, 2'd0, 8'hFF, 8'hFF},
        {4'd0, 4'd6, 1'b1, 1'b1, 2'd2, 8'b1011_0110, 8'hFF},
        {4'd0, 4'd4, 1'b1, 1'b1, 2'd0, 8'hFF, 8'b1010_1101},
        {4'd0, 4'd1, 1'b1, 1'b1, 2'd0, 8'hFF, 8'hFF},
        {4'd0, 4'd7, 1'b1, 1'b1, 2'd1, 8'b1110_1101, 8'b0111_1011},
        {4'd4, 4'd2, 1'b0, 1'b1, 2'd0, 8'b0110_1110, 8'b1101_0111}
    };

    task automatic ceq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] word(input int v, input int k);
        return {8'hA0 + 8'(v), 24'(k), 8'h50 + 8'(v), 24'(k) ^ 24'h00FF00};
    endfunction

    function automatic logic [7:0] bev(input int v, input int k);
        return 8'(k * 37 + v * 5);
    endfunction

    function automatic logic [63:0] addrv(input int v);
        return {32'h0, 32'h8000_0000 | 32'(v << 8)};
    endfunction

    task automatic run_vec(input int vi, input logic [27:0] v);
        int gd = int'(v[27:24]);
        int len = int'(v[23:20]);
        bit w64 = v[19];
        bit a64 = v[18];
        int dly = int'(v[17:16]);
        logic [7:0] rp = v[15:8];
        logic [7:0] tp = v[7:0];
        bit r64 = w64 && a64;
        int ph = 0, widx = 0, cyc = 0, strobes = 0, dcyc = -1, addr_cyc = -1, after = 0;
        bit done = 0, addr_seen = 0, prev_xfer = 0, prev_irdy_n = 1, prev_adoe = 0, dev_on = 0;
        logic [63:0] prev_ad = '0;
        logic [63:0] ew;
        @(posedge clk); #1;
        loc_req = 1'b1; loc_want64 = w64; loc_len = 8'(len);
        loc_data = addrv(vi); loc_rdy = 1'b0; pci_gnt_n = (gd > 0);
        while (!done && cyc < 300) begin
            @(negedge clk);
            if (after == 2) begin
                ceq("R11 irdy_oe released", 64'(irdy_oe), 64'd0);
                ceq("R11 par_oe released", 64'(par_oe), 64'd0);
                done = 1;
            end else if (after == 1) begin
                ceq("R10 bus groups released",
                    64'({frame_oe, req64_oe, ad_lo_oe, ad_hi_oe, cbe_lo_oe, cbe_hi_oe}), 64'd0);
                ceq("R10 irdy driven high", 64'({irdy_oe, irdy_n_o}), 64'b11);
                ceq("R10 burst count zero", 64'(loc_burst_cnt), 64'd0);
                ceq("R10 status/term", 64'({loc_status, loc_term}), 64'({4'h8, 2'b01}));
                after = 2;
            end else begin
                if (cyc == 1) ceq("R3 request asserted", 64'(pci_req_n), 64'd0);
                if (!addr_seen && cyc >= 1 && cyc <= gd)
                    ceq("R3 no frame before grant", 64'(frame_oe), 64'd0);
                if (!addr_seen && frame_oe) begin
                    addr_seen = 1;
                    addr_cyc = cyc;
                    ceq("R3 address phase cycle", 64'(cyc), 64'((gd > 1 ? gd : 1) + 1));
                    ceq("R4 address", 64'(ad_o[31:0]), 64'(addrv(vi)));
                    ceq("R4 command", 64'(cbe_o[3:0]), 64'b0111);
                    ceq("R4 frame low", 64'(frame_n_o), 64'd0);
                    ceq("R4 req64", 64'(req64_n_o), 64'(!w64));
                end else if (addr_seen && cyc == addr_cyc + 1) begin
                    ceq("R3 request dropped", 64'(pci_req_n), 64'd1);
                end
                if (dcyc == 1 || dcyc == 2)
                    ceq("R5 width window idle", 64'({irdy_n_o, loc_xfer_lo, loc_xfer_hi}), 64'b100);
                if (dcyc == 3) begin
                    ceq("R5 first take", 64'(loc_xfer_lo), 64'(loc_rdy));
                    ceq("R5 width result", 64'(loc_is64), 64'(r64));
                    ceq("R5 data status", 64'(loc_status), 64'h4);
                end
                if (!r64 && dcyc >= 3)
                    ceq("R13 high half unused", 64'({ad_hi_oe, cbe_hi_oe, loc_xfer_hi}), 64'd0);
                if (irdy_oe && !irdy_n_o && prev_irdy_n)
                    ceq("R7 irdy follows take", 64'(prev_xfer), 64'd1);
                if (dcyc >= 3 && irdy_oe && irdy_n_o && !prev_xfer && prev_adoe && ad_lo_oe)
                    ceq("R12 wait holds bus", {ad_o[63:1], frame_n_o}, {prev_ad[63:1], 1'b0});
                if (irdy_oe && !irdy_n_o && !pci_trdy_n) begin
                    ew = word(vi, ph);
                    ceq("R6 low data", 64'(ad_o[31:0]), 64'(ew[31:0]));
                    ceq("R6 low byte enables", 64'(cbe_o[3:0]), 64'(bev(vi, ph) & 8'h0F));
                    if (r64) begin
                        ceq("R6 high data", 64'(ad_o[63:32]), 64'(ew[63:32]));
                        ceq("R6 high byte enables", 64'(cbe_o[7:4]), 64'(bev(vi, ph) >> 4));
                    end
                    ceq("R8 burst count", 64'(loc_burst_cnt), 64'(len - ph));
                    if (ph == len - 1) begin
                        ceq("R9 last frame/req64 high", 64'({frame_n_o, req64_n_o}), 64'b11);
                        ceq("R9 no strobe on last", 64'(loc_xfer_lo), 64'd0);
                        after = 1;
                    end else begin
                        ceq("R9 frame low mid-burst", 64'(frame_n_o), 64'd0);
                    end
                    ph++;
                end
                if (loc_xfer_lo) strobes++;
            end
            prev_xfer = loc_xfer_lo;
            prev_irdy_n = irdy_n_o;
            prev_adoe = ad_lo_oe;
            prev_ad = {ad_o[63:1], 1'b0};
            ceq("R2 grant mirror", 64'(loc_gnt_n), 64'(pci_gnt_n));
            @(posedge clk); #1;
            cyc++;
            loc_req = 1'b0;
            pci_gnt_n = (cyc < gd);
            if (prev_xfer) widx++;
            loc_data = addr_seen ? word(vi, widx) : addrv(vi);
            loc_be = bev(vi, widx);
            loc_rdy = addr_seen ? rp[cyc % 8] : 1'b0;
            dev_on = addr_seen && (cyc >= addr_cyc + 1 + dly) && (after == 0);
            if (dcyc >= 0) dcyc++;
            else if (dev_on) dcyc = 0;
            pci_devsel_n = !dev_on;
            pci_ack64_n = !(dev_on && a64);
            pci_trdy_n = !(dev_on && tp[cyc % 8]);
        end
        ceq("R6 transfer finished", 64'(done), 64'd1);
        ceq("R6 strobe count", 64'(strobes), 64'(len));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog R1..13 act=hung exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        ceq("R1 enables low",
            64'({frame_oe, req64_oe, irdy_oe, ad_lo_oe, ad_hi_oe, cbe_lo_oe, cbe_hi_oe, par_oe}), 64'd0);
        ceq("R1 request idle", 64'(pci_req_n), 64'd1);
        ceq("R1 strobes low", 64'({loc_xfer_lo, loc_xfer_hi, loc_is64}), 64'd0);
        ceq("R1 status idle", 64'({loc_status, loc_term, loc_burst_cnt}), 64'd0);
        // R2 grant mirror both levels
        pci_gnt_n = 1'b0; #1;
        ceq("R2 grant low", 64'(loc_gnt_n), 64'd0);
        pci_gnt_n = 1'b1; #1;
        ceq("R2 grant high", 64'(loc_gnt_n), 64'd1);
        for (int i = 0; i < 8; i++) begin
            run_vec(i, VEC[i]);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end
endmodule